// File: doc/BRIEF.md
# External Bus Wait-State Sequencer

This block drives the timing of one access at a time to an external memory area. The area is split into four chip-select regions. When an access starts, the block takes the target region, the transfer direction and the bus mode (separate or multiplexed address/data). It combines these with a global software-wait bit and three per-region fields: a no-wait bit, a 2-bit wait code and a 2-bit extended code. From that combination it chooses a setup length and a strobe length in bus-clock cycles.

During the whole access the block holds the region's chip select. In the strobe phase it also drives the read or write strobe. An external ready input can hold the strobe longer, but only for accesses timed in wait mode. A one-cycle completion pulse follows the access. If the configuration is illegal, the block times the access with the nearest legal setting and sets a sticky error flag.

Top module: `ext_wait_seq`

## Requirements
- R1: Out of reset, `cs_o` is 0 and `rd_o`, `wr_o`, `done_o`, `busy_o` and `cfg_err_o` are low. With every configuration input at 0, an access takes one setup cycle and one strobe cycle.
- R2: With the global bit at 0, the region's no-wait bit at 1 and a separate bus, a read is 0 setup + 1 strobe cycle and a write is 1 setup + 1 strobe cycle.
- R3: In wait mode (effective no-wait 0) on a separate bus, wait codes 00, 01 and 10 give 1 setup cycle followed by 1, 2 or 3 strobe cycles.
- R4: In wait mode on a separate bus, wait code 11 selects the extended code. Extended codes 00, 01, 10 and 11 give setup+strobe of 2+3, 2+4, 3+4 and 4+5 cycles.
- R5: In wait mode on a multiplexed bus, wait codes 00 and 01 give 1+2 cycles and code 10 gives 1+3 cycles.
- R6: The global bit set to 1 with a region in wait mode and code 00 gives 2 cycles on a separate bus and 3 cycles on a multiplexed bus.
- R7: Some combinations are illegal: the no-wait bit at 1 together with a multiplexed bus or the global bit at 1, and a multiplexed bus with wait code 11. Such an access is timed as wait mode, with code 11 on a multiplexed bus treated as 10. It sets `cfg_err_o`, which stays high until reset.
- R8: In wait mode, ready sampled low at the last strobe cycle extends the strobe by one cycle per low sample. In no-wait mode, ready is ignored.
- R9: `done_o` is high for one cycle, directly after the last strobe cycle. In that cycle `cs_o` is 0, and a new `start_i` is accepted.
- R10: The configuration, region, direction and mode are captured when an access starts. Input changes during the access, and `start_i` while busy, do not affect it.
- R11: `cs_o` bit i is the only bit high during an access to region i. `rd_o` is high only in the strobe phase of a read and `wr_o` only in the strobe phase of a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin an access (taken when idle) |
| region_i | input | 2 | Target region index |
| write_i | input | 1 | 1 = write, 0 = read |
| mux_i | input | 1 | 1 = multiplexed address/data bus |
| sw_wait_i | input | 1 | Global software-wait bit |
| fast_i | input | 4 | Per-region no-wait bit (1 = no wait) |
| wcnt_i | input | 8 | Per-region 2-bit wait codes, region i at bits 2i+1:2i |
| ext_i | input | 8 | Per-region 2-bit extended codes, region i at bits 2i+1:2i |
| ready_i | input | 1 | External ready, active high |
| cs_o | output | 4 | One-hot chip selects |
| rd_o | output | 1 | Read strobe |
| wr_o | output | 1 | Write strobe |
| busy_o | output | 1 | Access in progress |
| done_o | output | 1 | Access complete pulse |
| cfg_err_o | output | 1 | Sticky illegal-configuration flag |

## Verification
The hardest situation to reach is a change to the configuration inputs while an access is in flight. The bench must confirm that the change is not latched, together with a second start pulse arriving while the block is busy. The driver does this partway into a long extended-code access: it inverts every field of the active region and the mode bits, and pulses start toward another region. The scoreboard still expects the timing that was captured when the access began. Ready stalls are placed by counting cycles from the start edge, so the low sample falls exactly on the last strobe cycle. In no-wait mode the same low ready must leave the timing unchanged.

// File: rtl/ews_pkg.sv
package ews_pkg;
  localparam int unsigned CNT_W = 3;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SETUP,
    ST_STROBE
  } ews_state_e;

  typedef struct packed {
    logic [CNT_W-1:0] setup;
    logic [CNT_W-1:0] strobe;
    logic             rdy_en;
    logic             err;
  } ews_timing_t;
endpackage

// File: rtl/ews_region_sel.sv
module ews_region_sel #(
  parameter int unsigned REGIONS = 4,
  parameter int unsigned FLD_W   = 2,
  localparam int unsigned RW     = $clog2(REGIONS)
) (
  input  logic [RW-1:0]            region_i,
  input  logic [REGIONS-1:0]       fast_i,
  input  logic [REGIONS*FLD_W-1:0] wcnt_i,
  input  logic [REGIONS*FLD_W-1:0] ext_i,
  output logic                     fast_o,
  output logic [FLD_W-1:0]         wcnt_o,
  output logic [FLD_W-1:0]         ext_o
);
  logic [FLD_W-1:0] wcnt_arr [REGIONS];
  logic [FLD_W-1:0] ext_arr  [REGIONS];

  for (genvar g = 0; g < REGIONS; g++) begin : g_unpack
    assign wcnt_arr[g] = wcnt_i[g*FLD_W +: FLD_W];
    assign ext_arr[g]  = ext_i[g*FLD_W +: FLD_W];
  end

  assign fast_o = fast_i[region_i];
  assign wcnt_o = wcnt_arr[region_i];
  assign ext_o  = ext_arr[region_i];
endmodule

// File: rtl/ews_decode.sv
module ews_decode
  import ews_pkg::*;
(
  input  logic        write_i,
  input  logic        mux_i,
  input  logic        sw_wait_i,
  input  logic        fast_i,
  input  logic [1:0]  wcnt_i,
  input  logic [1:0]  ext_i,
  output ews_timing_t timing_o
);
  logic wait_mode;

  // illegal no-wait requests fall back to wait mode
  assign wait_mode = ~fast_i | mux_i | sw_wait_i;

  always_comb begin
    timing_o        = '0;
    timing_o.rdy_en = wait_mode;
    timing_o.err    = (fast_i & (mux_i | sw_wait_i)) | (mux_i & (wcnt_i == 2'b11));
    if (!wait_mode) begin
      timing_o.setup  = write_i ? CNT_W'(1) : CNT_W'(0);
      timing_o.strobe = CNT_W'(1);
    end else if (mux_i) begin
      timing_o.setup  = CNT_W'(1);
      timing_o.strobe = wcnt_i[1] ? CNT_W'(3) : CNT_W'(2);
    end else if (wcnt_i != 2'b11) begin
      timing_o.setup  = CNT_W'(1);
      timing_o.strobe = CNT_W'(wcnt_i) + CNT_W'(1);
    end else begin
      unique case (ext_i)
        2'b00: begin timing_o.setup = CNT_W'(2); timing_o.strobe = CNT_W'(3); end
        2'b01: begin timing_o.setup = CNT_W'(2); timing_o.strobe = CNT_W'(4); end
        2'b10: begin timing_o.setup = CNT_W'(3); timing_o.strobe = CNT_W'(4); end
        default: begin timing_o.setup = CNT_W'(4); timing_o.strobe = CNT_W'(5); end
      endcase
    end
  end
endmodule

// File: rtl/ews_fsm.sv
module ews_fsm
  import ews_pkg::*;
#(
  parameter int unsigned REGIONS = 4,
  localparam int unsigned RW     = $clog2(REGIONS)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic [RW-1:0]      region_i,
  input  logic               write_i,
  input  logic [CNT_W-1:0]   setup_i,
  input  logic [CNT_W-1:0]   strobe_i,
  input  logic               rdy_en_i,
  input  logic               ready_i,
  output logic               accept_o,
  output logic [REGIONS-1:0] cs_o,
  output logic               rd_o,
  output logic               wr_o,
  output logic               busy_o,
  output logic               done_o
);
  ews_state_e       state_q;
  logic [CNT_W-1:0] cnt_q, strobe_len_q;
  logic [RW-1:0]    region_q;
  logic             write_q, rdy_en_q, done_q;

  assign accept_o = start_i & (state_q == ST_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q      <= ST_IDLE;
      cnt_q        <= '0;
      strobe_len_q <= '0;
      region_q     <= '0;
      write_q      <= 1'b0;
      rdy_en_q     <= 1'b0;
      done_q       <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (accept_o) begin
          region_q     <= region_i;
          write_q      <= write_i;
          rdy_en_q     <= rdy_en_i;
          strobe_len_q <= strobe_i;
          if (setup_i != '0) begin
            state_q <= ST_SETUP;
            cnt_q   <= setup_i;
          end else begin
            state_q <= ST_STROBE;
            cnt_q   <= strobe_i;
          end
        end
        ST_SETUP: begin
          if (cnt_q == CNT_W'(1)) begin
            state_q <= ST_STROBE;
            cnt_q   <= strobe_len_q;
          end else begin
            cnt_q <= cnt_q - CNT_W'(1);
          end
        end
        ST_STROBE: begin
          if (cnt_q != CNT_W'(1)) begin
            cnt_q <= cnt_q - CNT_W'(1);
          end else if (ready_i || !rdy_en_q) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  for (genvar g = 0; g < REGIONS; g++) begin : g_cs
    assign cs_o[g] = (state_q != ST_IDLE) && (region_q == RW'(g));
  end

  assign rd_o   = (state_q == ST_STROBE) & ~write_q;
  assign wr_o   = (state_q == ST_STROBE) & write_q;
  assign busy_o = state_q != ST_IDLE;
  assign done_o = done_q;

  a_r11_cs_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(cs_o));
  a_r11_strobe_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rd_o && wr_o) && ((rd_o || wr_o) -> (|cs_o)));
  a_r8_fast_no_stretch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_STROBE && cnt_q == CNT_W'(1) && !rdy_en_q) |=> (state_q == ST_IDLE));
  a_r9_done_after_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (cs_o == '0) && $past(rd_o || wr_o));
  a_r10_busy_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i) |=> $stable(region_q) && $stable(write_q) && $stable(strobe_len_q));
  a_r3_strobe_nonzero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_o |-> (strobe_i != '0));
endmodule

// File: rtl/ext_wait_seq.sv
module ext_wait_seq
  import ews_pkg::*;
#(
  parameter int unsigned REGIONS = 4,
  parameter int unsigned FLD_W   = 2,
  localparam int unsigned RW     = $clog2(REGIONS)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     start_i,
  input  logic [RW-1:0]            region_i,
  input  logic                     write_i,
  input  logic                     mux_i,
  input  logic                     sw_wait_i,
  input  logic [REGIONS-1:0]       fast_i,
  input  logic [REGIONS*FLD_W-1:0] wcnt_i,
  input  logic [REGIONS*FLD_W-1:0] ext_i,
  input  logic                     ready_i,
  output logic [REGIONS-1:0]       cs_o,
  output logic                     rd_o,
  output logic                     wr_o,
  output logic                     busy_o,
  output logic                     done_o,
  output logic                     cfg_err_o
);
  logic             sel_fast, accept;
  logic [FLD_W-1:0] sel_wcnt, sel_ext;
  ews_timing_t      timing;
  logic             err_q;

  ews_region_sel #(.REGIONS(REGIONS), .FLD_W(FLD_W)) u_sel (
    .region_i(region_i), .fast_i(fast_i), .wcnt_i(wcnt_i), .ext_i(ext_i),
    .fast_o(sel_fast), .wcnt_o(sel_wcnt), .ext_o(sel_ext)
  );

  ews_decode u_dec (
    .write_i(write_i), .mux_i(mux_i), .sw_wait_i(sw_wait_i), .fast_i(sel_fast),
    .wcnt_i(sel_wcnt[1:0]), .ext_i(sel_ext[1:0]), .timing_o(timing)
  );

  ews_fsm #(.REGIONS(REGIONS)) u_fsm (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .region_i(region_i),
    .write_i(write_i), .setup_i(timing.setup), .strobe_i(timing.strobe),
    .rdy_en_i(timing.rdy_en), .ready_i(ready_i), .accept_o(accept),
    .cs_o(cs_o), .rd_o(rd_o), .wr_o(wr_o), .busy_o(busy_o), .done_o(done_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) err_q <= 1'b0;
    else if (accept && timing.err) err_q <= 1'b1;
  end

  assign cfg_err_o = err_q;

  a_r7_err_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_err_o |=> cfg_err_o);
  a_r7_err_source: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cfg_err_o) |-> $past(start_i && !busy_o));
endmodule

// File: tb/tb_ext_wait_seq.sv
module tb_ext_wait_seq;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start_i = 1'b0;
  logic [1:0] region_i = '0;
  logic       write_i = 1'b0, mux_i = 1'b0, sw_wait_i = 1'b0, ready_i = 1'b1;
  logic [3:0] fast_i = '0;
  logic [7:0] wcnt_i = '0, ext_i = '0;
  logic [3:0] cs_o;
  logic       rd_o, wr_o, busy_o, done_o, cfg_err_o;

  int n_checks = 0;
  int n_fails  = 0;

  typedef struct {
    int    region;
    bit    wr;
    int    s;
    int    p;
    string tag;
  } exp_t;
  exp_t exp_q[$];

  always #5 clk = ~clk;

  ext_wait_seq dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start_i), .region_i(region_i),
    .write_i(write_i), .mux_i(mux_i), .sw_wait_i(sw_wait_i), .fast_i(fast_i),
    .wcnt_i(wcnt_i), .ext_i(ext_i), .ready_i(ready_i), .cs_o(cs_o),
    .rd_o(rd_o), .wr_o(wr_o), .busy_o(busy_o), .done_o(done_o), .cfg_err_o(cfg_err_o)
  );

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("  %0d/%0d checks passed", n_checks - n_fails, n_checks);
  endtask

  // expected phases from the requirement tables
  task automatic expect_phases(input bit wr, input bit mux, input bit gw, input bit fast,
                               input int wc, input int ew, output int s, output int p,
                               output bit wait_mode);
    wait_mode = !fast || mux || gw;
    if (!wait_mode) begin s = wr ? 1 : 0; p = 1; end
    else if (mux) begin s = 1; p = (wc >= 2) ? 3 : 2; end
    else if (wc < 3) begin s = 1; p = wc + 1; end
    else begin
      case (ew)
        0: begin s = 2; p = 3; end
        1: begin s = 2; p = 4; end
        2: begin s = 3; p = 4; end
        default: begin s = 4; p = 5; end
      endcase
    end
  endtask

  task automatic do_access(input int region, input bit wr, input bit mux, input bit gw,
                           input bit fast, input int wc, input int ew, input int stall,
                           input bit disturb, input string tag);
    int s, p, k, target;
    bit wm, seen;
    exp_t e;
    expect_phases(wr, mux, gw, fast, wc, ew, s, p, wm);
    e.region = region; e.wr = wr; e.s = s; e.p = p + (wm ? stall : 0); e.tag = tag;
    exp_q.push_back(e);
    start_i = 1'b1; region_i = 2'(region); write_i = wr; mux_i = mux; sw_wait_i = gw;
    fast_i[region] = fast;
    wcnt_i[2*region +: 2] = 2'(wc);
    ext_i[2*region +: 2]  = 2'(ew);
    ready_i = (stall == 0);
    target = (stall == 0) ? 0 : s + p + stall;
    k = 0; seen = 1'b0;
    while (!(seen && k >= target)) begin
      @(negedge clk);
      k++;
      if (k == 1) begin
        start_i = 1'b0;
        if (disturb) begin
          fast_i[region] = ~fast; write_i = ~wr; mux_i = ~mux; sw_wait_i = ~gw;
          wcnt_i[2*region +: 2] = ~2'(wc);
          ext_i[2*region +: 2]  = ~2'(ew);
        end
      end
      if (disturb && k == 2) begin start_i = 1'b1; region_i = 2'(region + 1); end
      if (disturb && k == 3) start_i = 1'b0;
      if (k == target) ready_i = 1'b1;
      if (done_o) seen = 1'b1;
    end
  endtask

  // monitor / scoreboard
  int  m_s = 0, m_p = 0, m_region = -1;
  bit  m_wr = 1'b0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (|cs_o) begin
        if (rd_o || wr_o) m_p++; else m_s++;
        if (wr_o) m_wr = 1'b1;
        for (int i = 0; i < 4; i++) if (cs_o[i]) m_region = i;
        chk($countones(cs_o) == 1, "R11", "cs one-hot count", $countones(cs_o), 1);
      end
      if (done_o) begin
        chk(cs_o == 4'b0, "R9", "cs during done", int'(cs_o), 0);
        if (exp_q.size() == 0) begin
          chk(1'b0, "R9", "unexpected done, queue size", 0, 1);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          chk(m_s == e.s, e.tag, "setup cycles", m_s, e.s);
          chk(m_p == e.p, e.tag, "strobe cycles", m_p, e.p);
          chk(m_region == e.region, e.tag, "region (R11)", m_region, e.region);
          chk(m_wr == e.wr, e.tag, "write strobe seen (R11)", int'(m_wr), int'(e.wr));
        end
        m_s = 0; m_p = 0; m_region = -1; m_wr = 1'b0;
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    chk(1'b0, "WDOG", "watchdog expired", 1, 0);
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(cs_o == 4'b0 && !rd_o && !wr_o && !done_o && !busy_o, "R1", "outputs in reset",
        int'({cs_o, rd_o, wr_o, done_o, busy_o}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cfg_err_o == 1'b0, "R1", "cfg_err after reset", int'(cfg_err_o), 0);
    chk(!busy_o && cs_o == 4'b0, "R1", "idle after reset", int'(busy_o), 0);

    // R1 default configuration: one wait state
    do_access(0, 0, 0, 0, 0, 0, 0, 0, 0, "R1");
    // R2 no-wait separate bus
    do_access(1, 0, 0, 0, 1, 0, 0, 0, 0, "R2");
    do_access(2, 1, 0, 0, 1, 2, 3, 0, 0, "R2");
    // R3 wait codes
    for (int c = 0; c < 3; c++) begin
      do_access(3, 0, 0, 0, 0, c, 0, 0, 0, "R3");
      do_access(c, 1, 0, 0, 0, c, 2, 0, 0, "R3");
    end
    // R4 extended codes
    for (int x = 0; x < 4; x++) do_access(x, x[0], 0, 0, 0, 3, x, 0, 0, "R4");
    // R5 multiplexed
    for (int c = 0; c < 3; c++) do_access(c + 1, c[0], 1, 0, 0, c, 1, 0, 0, "R5");
    // R6 global wait bit
    do_access(2, 0, 0, 1, 0, 0, 0, 0, 0, "R6");
    do_access(3, 1, 1, 1, 0, 0, 0, 0, 0, "R6");
    // R8 ready stall in wait mode, then ignored in no-wait mode
    do_access(1, 0, 0, 0, 0, 1, 0, 2, 0, "R8");
    do_access(0, 1, 0, 0, 0, 3, 2, 1, 0, "R8");
    do_access(2, 0, 0, 0, 1, 0, 0, 3, 0, "R8");
    do_access(3, 1, 0, 0, 1, 0, 0, 2, 0, "R8");
    // R10 mid-access changes and start while busy
    do_access(0, 1, 0, 0, 0, 3, 3, 0, 1, "R10");
    do_access(2, 0, 1, 0, 0, 2, 0, 0, 1, "R10");
    @(negedge clk);
    chk(cfg_err_o == 1'b0, "R7", "cfg_err before illegal use", int'(cfg_err_o), 0);
    // R7 illegal combinations
    do_access(1, 0, 1, 0, 1, 1, 0, 0, 0, "R7");
    @(negedge clk);
    chk(cfg_err_o == 1'b1, "R7", "cfg_err after no-wait+mux", int'(cfg_err_o), 1);
    do_access(2, 1, 0, 1, 1, 2, 0, 2, 0, "R7");
    do_access(3, 0, 1, 0, 0, 3, 0, 0, 0, "R7");
    do_access(0, 0, 0, 0, 1, 0, 0, 0, 0, "R7");
    @(negedge clk);
    chk(cfg_err_o == 1'b1, "R7", "cfg_err sticky after legal access", int'(cfg_err_o), 1);
    repeat (2) @(negedge clk);
    chk(exp_q.size() == 0, "R9", "accesses left without done", exp_q.size(), 0);
    summary();
    $finish;
  end
endmodule